// File: doc/BRIEF.md
# Pixel Persistence Age Tracker

This block gives a point-plotted vector image a phosphor-like afterglow on a raster framebuffer. Every stored pixel word carries a small frame stamp next to its color. The writer that plots incoming beam samples stamps each pixel with the block's running frame number. A sweep engine walks the framebuffer as a second write producer. It reads each word, works out the pixel's age against the current frame number, and rewrites any pixel that has outlived a programmable limit. In clear mode such a pixel is erased. In dim mode each of its color channels is halved and it is restamped, so it fades step by step until it is erased.

The display read path goes through the same age test. A pixel that has aged past the limit is shown as black even before the sweep reaches it. The source image refreshes more slowly than the display, so the limit is set to span several display frames. The framebuffer and its arbitration sit outside the block; the sweep sees a plain request/grant port.

Top module: `pix_persist`

## Requirements
- R1: The frame counter `frame_o` is STAMP_W bits wide and is 0 after reset. It increments by one, wrapping modulo 2^STAMP_W, on every clock in which `frame_tick_i` is high, and holds otherwise.
- R2: A pixel word is {stamp[STAMP_W], red[COLOR_W], green[COLOR_W], blue[COLOR_W]}, with the stamp in the most significant bits and blue in the least significant bits. Its age is (frame_o − stamp) mod 2^STAMP_W. One clock after `disp_valid_i`/`disp_pix_i` are applied, `disp_valid_o` equals `disp_valid_i`. `disp_rgb_o` equals the color field when the input was valid and age ≤ `age_limit_i`, and 0 otherwise.
- R3: While a sweep access is requested and not granted, `sw_addr_o` holds. A pending write also keeps `sw_we_o` and `sw_wdata_o` unchanged.
- R4: Read data on `sw_rdata_i` is taken in the clock cycle that follows the cycle in which a read was granted.
- R5: In clear mode (`dim_mode_i` = 0), a pixel that has expired (age > limit) and has a nonzero color is rewritten to all zeros at the same address.
- R6: In dim mode (`dim_mode_i` = 1), an expired pixel with a nonzero color is rewritten with each channel shifted right by one and with its stamp set to the current frame. If all channels become 0, the word written is all zeros.
- R7: A pixel that has not expired, or whose color is 0, is not written.
- R8: Reads proceed through consecutive addresses 0, 1, …, NUM_PIX−1 and then wrap to 0. `sw_addr_o` never reaches NUM_PIX or beyond.
- R9: While `sweep_en_i` is low and no write is pending, `sw_req_o` stays low and the framebuffer is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_tick_i | input | 1 | Advances the frame counter by one |
| age_limit_i | input | STAMP_W | Largest age still shown |
| dim_mode_i | input | 1 | 1: halve expired pixels, 0: erase them |
| sweep_en_i | input | 1 | Lets the sweep start new reads |
| frame_o | output | STAMP_W | Current frame number, used by the plotter as its stamp |
| sw_req_o | output | 1 | Sweep memory access request |
| sw_we_o | output | 1 | Request is a write |
| sw_addr_o | output | ADDR_W | Sweep address |
| sw_wdata_o | output | PIX_W | Sweep write data |
| sw_gnt_i | input | 1 | Access granted this cycle |
| sw_rdata_i | input | PIX_W | Read data, one cycle after a read grant |
| disp_valid_i | input | 1 | Display pixel word valid |
| disp_pix_i | input | PIX_W | Pixel word read by the display path |
| disp_valid_o | output | 1 | Delayed valid |
| disp_rgb_o | output | 3*COLOR_W | Color, forced to black when stale |

## Verification
The bench aims at stamp wraparound, where a stamp numerically larger than the frame still yields a small age. A design that compares stamp and frame without modular subtraction would blank fresh pixels there. It probes ages exactly at the limit and one beyond it; an off-by-one comparison flips those pixels. A randomly stalling grant checks that the address and the pending write hold. Complete sweep passes in both modes compare the whole memory against a model. Such a pass catches a dim step that does not restamp, does not clear on reaching zero, or writes blank or fresh pixels. Tracking every granted read address catches a sweep that skips a word or fails to wrap at NUM_PIX−1.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SW_RD   = 2'd0,
    SW_EVAL = 2'd1,
    SW_WR   = 2'd2
  } sweep_st_e;
endpackage

// File: rtl/pp_frame_ctr.sv
module pp_frame_ctr #(
  parameter int STAMP_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  output logic [STAMP_W-1:0] frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_o <= '0;
    else if (tick_i) frame_o <= frame_o + 1'b1;
  end

  p_frame_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> frame_o == STAMP_W'($past(frame_o) + 1'b1));
  p_frame_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(frame_o));
endmodule

// File: rtl/pp_age_eval.sv
module pp_age_eval #(
  parameter int STAMP_W = 3,
  parameter int COLOR_W = 3,
  localparam int RGB_W  = 3 * COLOR_W,
  localparam int PIX_W  = STAMP_W + RGB_W
) (
  input  logic [PIX_W-1:0]   pix_i,
  input  logic [STAMP_W-1:0] frame_i,
  input  logic [STAMP_W-1:0] limit_i,
  input  logic               dim_i,
  output logic               expired_o,
  output logic               blank_o,
  output logic [RGB_W-1:0]   color_o,
  output logic [PIX_W-1:0]   next_o
);
  logic [STAMP_W-1:0] stamp;
  logic [STAMP_W-1:0] age;
  logic [RGB_W-1:0]   dimmed;

  assign stamp   = pix_i[PIX_W-1 -: STAMP_W];
  assign color_o = pix_i[RGB_W-1:0];
  // modular difference keeps ages correct across stamp wrap
  assign age       = frame_i - stamp;
  assign expired_o = age > limit_i;
  assign blank_o   = (color_o == '0);

  for (genvar ch = 0; ch < 3; ch++) begin : g_dim
    assign dimmed[ch*COLOR_W +: COLOR_W] = color_o[ch*COLOR_W +: COLOR_W] >> 1;
  end

  always_comb begin
    next_o = '0;
    if (dim_i && (dimmed != '0)) next_o = {frame_i, dimmed};
  end
endmodule

// File: rtl/pp_sweep.sv
module pp_sweep
  import pp_pkg::*;
#(
  parameter int NUM_PIX = 200,
  parameter int STAMP_W = 3,
  parameter int COLOR_W = 3,
  localparam int ADDR_W = $clog2(NUM_PIX),
  localparam int PIX_W  = STAMP_W + 3 * COLOR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [STAMP_W-1:0] frame_i,
  input  logic [STAMP_W-1:0] limit_i,
  input  logic               dim_i,
  output logic               req_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [PIX_W-1:0]   wdata_o,
  input  logic               gnt_i,
  input  logic [PIX_W-1:0]   rdata_i
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_PIX - 1);

  sweep_st_e            state;
  logic [ADDR_W-1:0]    addr_q;
  logic [ADDR_W-1:0]    addr_nxt;
  logic [PIX_W-1:0]     wdata_q;
  logic                 expired;
  logic                 blank;
  logic [3*COLOR_W-1:0] color_unused;
  logic [PIX_W-1:0]     next_pix;

  pp_age_eval #(.STAMP_W(STAMP_W), .COLOR_W(COLOR_W)) u_eval (
    .pix_i     (rdata_i),
    .frame_i   (frame_i),
    .limit_i   (limit_i),
    .dim_i     (dim_i),
    .expired_o (expired),
    .blank_o   (blank),
    .color_o   (color_unused),
    .next_o    (next_pix)
  );

  assign addr_nxt = (addr_q == LAST) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= SW_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state)
        SW_RD:   if (en_i && gnt_i) state <= SW_EVAL;
        SW_EVAL: begin
          if (expired && !blank) begin
            wdata_q <= next_pix;
            state   <= SW_WR;
          end else begin
            addr_q <= addr_nxt;
            state  <= SW_RD;
          end
        end
        SW_WR: if (gnt_i) begin
          addr_q <= addr_nxt;
          state  <= SW_RD;
        end
        default: state <= SW_RD;
      endcase
    end
  end

  assign req_o   = ((state == SW_RD) && en_i) || (state == SW_WR);
  assign we_o    = (state == SW_WR);
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

  p_addr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= LAST);
  p_hold_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> $stable(addr_o));
  p_hold_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !gnt_i) |=> we_o && req_o && $stable(wdata_o));
  p_eval_after_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && !we_o) |=> state == SW_EVAL);
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && gnt_i && addr_o == LAST) |=> addr_o == '0);
endmodule

// File: rtl/pp_disp_gate.sv
module pp_disp_gate #(
  parameter int STAMP_W = 3,
  parameter int COLOR_W = 3,
  localparam int RGB_W  = 3 * COLOR_W,
  localparam int PIX_W  = STAMP_W + RGB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STAMP_W-1:0] frame_i,
  input  logic [STAMP_W-1:0] limit_i,
  input  logic               valid_i,
  input  logic [PIX_W-1:0]   pix_i,
  output logic               valid_o,
  output logic [RGB_W-1:0]   rgb_o
);
  logic             expired;
  logic             blank_unused;
  logic [RGB_W-1:0] color;
  logic [PIX_W-1:0] next_unused;

  pp_age_eval #(.STAMP_W(STAMP_W), .COLOR_W(COLOR_W)) u_eval (
    .pix_i     (pix_i),
    .frame_i   (frame_i),
    .limit_i   (limit_i),
    .dim_i     (1'b0),
    .expired_o (expired),
    .blank_o   (blank_unused),
    .color_o   (color),
    .next_o    (next_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rgb_o   <= '0;
    end else begin
      valid_o <= valid_i;
      rgb_o   <= (valid_i && !expired) ? color : '0;
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_black_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> rgb_o == '0);
endmodule

// File: rtl/pix_persist.sv
module pix_persist #(
  parameter int NUM_PIX = 200,
  parameter int STAMP_W = 3,
  parameter int COLOR_W = 3,
  localparam int ADDR_W = $clog2(NUM_PIX),
  localparam int RGB_W  = 3 * COLOR_W,
  localparam int PIX_W  = STAMP_W + RGB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_tick_i,
  input  logic [STAMP_W-1:0] age_limit_i,
  input  logic               dim_mode_i,
  input  logic               sweep_en_i,
  output logic [STAMP_W-1:0] frame_o,
  output logic               sw_req_o,
  output logic               sw_we_o,
  output logic [ADDR_W-1:0]  sw_addr_o,
  output logic [PIX_W-1:0]   sw_wdata_o,
  input  logic               sw_gnt_i,
  input  logic [PIX_W-1:0]   sw_rdata_i,
  input  logic               disp_valid_i,
  input  logic [PIX_W-1:0]   disp_pix_i,
  output logic               disp_valid_o,
  output logic [RGB_W-1:0]   disp_rgb_o
);
  logic [STAMP_W-1:0] frame;

  pp_frame_ctr #(.STAMP_W(STAMP_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (frame_tick_i),
    .frame_o (frame)
  );

  pp_sweep #(.NUM_PIX(NUM_PIX), .STAMP_W(STAMP_W), .COLOR_W(COLOR_W)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sweep_en_i),
    .frame_i (frame),
    .limit_i (age_limit_i),
    .dim_i   (dim_mode_i),
    .req_o   (sw_req_o),
    .we_o    (sw_we_o),
    .addr_o  (sw_addr_o),
    .wdata_o (sw_wdata_o),
    .gnt_i   (sw_gnt_i),
    .rdata_i (sw_rdata_i)
  );

  pp_disp_gate #(.STAMP_W(STAMP_W), .COLOR_W(COLOR_W)) u_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame),
    .limit_i (age_limit_i),
    .valid_i (disp_valid_i),
    .pix_i   (disp_pix_i),
    .valid_o (disp_valid_o),
    .rgb_o   (disp_rgb_o)
  );

  assign frame_o = frame;

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sweep_en_i && !sw_we_o) |-> !sw_req_o);
endmodule

// File: tb/pix_persist_tb.sv
`timescale 1ns/1ps
module pix_persist_tb;
  localparam int NUM_PIX = 200;
  localparam int SW      = 3;
  localparam int CW      = 3;
  localparam int AW      = $clog2(NUM_PIX);
  localparam int RW      = 3 * CW;
  localparam int PW      = SW + RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [SW-1:0] limit = '0;
  logic          dim = 1'b0;
  logic          sw_en = 1'b0;
  logic [SW-1:0] frame;
  logic          req, we, gnt;
  logic [AW-1:0] addr;
  logic [PW-1:0] wdata;
  logic [PW-1:0] rd_q;
  logic          dvi = 1'b0;
  logic [PW-1:0] dpix = '0;
  logic          dvo;
  logic [RW-1:0] drgb;

  logic [PW-1:0] mem [NUM_PIX];
  logic [PW-1:0] ref_mem [NUM_PIX];
  int checks = 0;
  int errors = 0;
  logic [SW-1:0] exp_frame = '0;

  always #2 clk = ~clk;

  pix_persist #(.NUM_PIX(NUM_PIX), .STAMP_W(SW), .COLOR_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick), .age_limit_i(limit),
    .dim_mode_i(dim), .sweep_en_i(sw_en), .frame_o(frame),
    .sw_req_o(req), .sw_we_o(we), .sw_addr_o(addr), .sw_wdata_o(wdata),
    .sw_gnt_i(gnt), .sw_rdata_i(rd_q), .disp_valid_i(dvi), .disp_pix_i(dpix),
    .disp_valid_o(dvo), .disp_rgb_o(drgb)
  );

  // framebuffer model, one-cycle read latency
  always @(posedge clk) begin
    if (req && gnt) begin
      if (we) mem[addr] <= wdata;
      else    rd_q      <= mem[addr];
    end
  end

  function automatic logic [SW-1:0] age_of(logic [PW-1:0] p, logic [SW-1:0] f);
    return f - p[PW-1 -: SW];
  endfunction

  function automatic logic [PW-1:0] swept(logic [PW-1:0] p, logic [SW-1:0] f,
                                          logic [SW-1:0] lim, logic d);
    logic [RW-1:0] c, h;
    c = p[RW-1:0];
    if (age_of(p, f) <= lim || c == '0) return p;
    if (!d) return '0;
    for (int ch = 0; ch < 3; ch++) h[ch*CW +: CW] = c[ch*CW +: CW] >> 1;
    if (h == '0) return '0;
    return {f, h};
  endfunction

  task automatic chk(bit ok, string req_tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // grant driver plus address-order and hold monitor
  logic [AW-1:0] exp_addr = '0;
  logic          p_req = 1'b0, p_gnt = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [PW-1:0] p_wdata = '0;
  initial begin
    gnt = 1'b0;
    forever begin
      @(negedge clk);
      gnt = ($urandom % 4) != 0;
      #1;
      if (rst_n) begin
        if (p_req && !p_gnt) begin
          chk(addr == p_addr, "R3 addr hold", addr, p_addr);
          if (p_we) chk(we && req && wdata == p_wdata, "R3 write hold", wdata, p_wdata);
        end
        if (req && gnt && !we) begin
          chk(addr == exp_addr, "R8 read order", addr, exp_addr);
          exp_addr = (exp_addr == AW'(NUM_PIX - 1)) ? '0 : exp_addr + 1'b1;
        end
        if (!sw_en && !we) chk(!req, "R9 idle request", req, 0);
      end
      p_req = req; p_gnt = gnt; p_we = we; p_addr = addr; p_wdata = wdata;
    end
  end

  task automatic frame_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      exp_frame = exp_frame + 1'b1;
      chk(frame == exp_frame, "R1 frame step", frame, exp_frame);
    end
  endtask

  task automatic disp_one(logic v, logic [PW-1:0] p);
    logic [RW-1:0] e;
    @(negedge clk);
    dvi = v; dpix = p;
    e = (v && age_of(p, exp_frame) <= limit) ? p[RW-1:0] : '0;
    @(negedge clk);
    chk(dvo == v, "R2 valid delay", dvo, v);
    chk(drgb == e, "R2 display gate", drgb, e);
    dvi = 1'b0;
  endtask

  task automatic sweep_pass(logic d, logic [SW-1:0] lim, int ticks, string tag);
    for (int i = 0; i < NUM_PIX; i++) begin
      mem[i] = PW'($urandom);
      if (i % 7 == 0) mem[i][RW-1:0] = '0;
    end
    @(negedge clk); dim = d; limit = lim;
    frame_ticks(ticks);
    for (int i = 0; i < NUM_PIX; i++) ref_mem[i] = swept(mem[i], exp_frame, lim, d);
    @(negedge clk); sw_en = 1'b1;
    repeat (3000) @(negedge clk);
    sw_en = 1'b0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < NUM_PIX; i++)
      chk(mem[i] == ref_mem[i], tag, mem[i], ref_mem[i]);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(frame == '0, "R1 reset frame", frame, 0);
    chk(!req && !dvo && drgb == '0, "R9 reset idle", req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 wraps past 2^STAMP_W
    frame_ticks(10);
    // R2 directed corners: limit 2, frame now 2
    limit = 3'd2;
    disp_one(1'b1, {exp_frame, 9'o765});               // age 0
    disp_one(1'b1, {SW'(exp_frame - 3'd2), 9'o123});   // age == limit, shown
    disp_one(1'b1, {SW'(exp_frame - 3'd3), 9'o777});   // age limit+1, black
    disp_one(1'b1, {SW'(exp_frame + 3'd1), 9'o444});   // wrap: age 7, black
    disp_one(1'b0, {exp_frame, 9'o777});               // invalid, black
    frame_ticks(5);                                    // frame 7
    disp_one(1'b1, {3'd6, 9'o321});                    // age 1
    frame_ticks(2);                                    // frame 1, wrapped
    disp_one(1'b1, {3'd7, 9'o321});                    // age 2 across wrap, shown
    // R2 random
    for (int i = 0; i < 40; i++) begin
      limit = SW'($urandom);
      if ($urandom % 5 == 0) frame_ticks(1);
      disp_one(($urandom % 6) != 0, PW'($urandom));
    end
    // R5 R7 R4 clear mode, R6 dim mode, R8 multiple wrapped passes
    sweep_pass(1'b0, 3'd2, 3, "R5/R7 clear pass");
    sweep_pass(1'b1, 3'd1, 4, "R6/R7 dim pass");
    sweep_pass(1'b1, 3'd0, 2, "R6 dim pass limit0");
    sweep_pass(1'b0, 3'd5, 6, "R5 clear pass limit5");
    // R9: sweep off, memory untouched under frame advance
    for (int i = 0; i < NUM_PIX; i++) ref_mem[i] = mem[i];
    frame_ticks(4);
    repeat (60) @(negedge clk);
    for (int i = 0; i < NUM_PIX; i++)
      chk(mem[i] == ref_mem[i], "R9 memory untouched", mem[i], ref_mem[i]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule